// File: doc/BRIEF.md
# Response Buffer Drain Sequencer

This block empties read response buffers without losing data that is still arriving. Sixteen buffers are described by two map words. Even-numbered buffers live in map 0 and odd-numbered buffers in map 1, with buffer `b` held in field `b>>1` of map `b[0]`. For every buffer the block watches two status inputs. The in-use input means transfers are still in flight, and the valid input means the buffer holds data. A one-cycle clear strobe, one bit per buffer, tells the buffer to discard its contents.

Three commands are accepted while the block is idle:
- A plain drain of one buffer that is already disabled.
- A single-buffer flush. It disables the buffer's field, drains it, then restores the enable.
- A slot-wide flush. It walks all eight fields of one map and flushes each field that belongs to a device.

Every wait is bounded by a programmable timeout. A timeout flags an error and stops the command. While a command runs, the block owns the maps: it reports busy, ignores other map writes and ignores new commands.

Top module: `resp_drain_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `clr_strobe` are 0 and both map words are 0.
- R2: A drain waits while the buffer's in-use input is 1. It then pulses that buffer's `clr_strobe` bit exactly once if valid is 1, and waits for valid to fall. If valid is already 0 when in-use falls, no strobe is issued.
- R3: `clr_strobe` has at most one bit set, and each pulse lasts one cycle.
- R4: Each field is 4 bits: bit 3 is enable, bit 2 is channel, bits 1:0 are device. A single-buffer flush (`cmd_op`=1) of a field whose enable is 1 holds that enable at 0 while the strobe is issued.
- R5: After any flush, every map field holds the value it had before the command.
- R6: A slot flush (`cmd_op`=2) uses map `cmd_slot[0]` and visits fields 0 to 7 in ascending order, which is buffer `2f+cmd_slot[0]`. It flushes a field when enable is 1 and device equals `cmd_slot[2:1]`, whatever the channel bit. Strobes therefore appear in ascending buffer order.
- R7: `done` is a one-cycle pulse after each accepted command ends, and `busy` is 0 in that cycle.
- R8: A wait whose condition holds for more than `tmo_limit` cycles sets `err` and ends the command. A saved enable is still restored and no further fields are visited. `err` returns to 0 when the next command is accepted.
- R9: While `busy` is 1, `map_we` and `cmd_valid` are ignored. A command with `cmd_op`=3 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 drain, 1 flush one buffer, 2 flush slot |
| cmd_buf | input | 4 | Buffer number for ops 0 and 1 |
| cmd_slot | input | 3 | Slot for op 2: bit 0 picks the map, bits 2:1 the device |
| tmo_limit | input | 16 | Wait timeout limit in cycles |
| buf_inuse | input | 16 | Per-buffer transfers-in-flight status |
| buf_valid | input | 16 | Per-buffer holds-data status |
| map_we | input | 1 | Map write strobe, honoured only when idle |
| map_sel | input | 1 | Map word selected for writing |
| map_wdata | input | 32 | Map write data |
| clr_strobe | output | 16 | One-cycle per-buffer clear pulse |
| map0_q | output | 32 | Map word 0 (even buffers) |
| map1_q | output | 32 | Map word 1 (odd buffers) |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Last command timed out |

## Verification
The assertions assume that a buffer's valid input does not rise on its own while that buffer is being drained. They also assume the status inputs change only between clock edges. The bench's buffer model follows both assumptions. It sets in-use countdowns and valid bits only while the block is idle. During a command it only counts in-use down and drops valid one to three cycles after the buffer's strobe. Stuck status bits are used only in the timeout cases, where the expected outcome is an error.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_DIS, S_WUSE, S_WVAL, S_REST, S_FIN
  } state_t;

  localparam logic [1:0] OP_DRAIN = 2'd0;
  localparam logic [1:0] OP_FLUSH = 2'd1;
  localparam logic [1:0] OP_SLOT  = 2'd2;
  localparam logic [1:0] OP_BAD   = 2'd3;
endpackage

// File: rtl/rdr_map_regs.sv
module rdr_map_regs #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   ext_we,
  input  logic                                   ext_sel,
  input  logic [NUM_FIELDS*FIELD_W-1:0]          ext_wdata,
  input  logic                                   en_we,
  input  logic [$clog2(2*NUM_FIELDS)-1:0]        en_buf,
  input  logic                                   en_val,
  output logic [1:0][NUM_FIELDS*FIELD_W-1:0]     map_q
);
  localparam int BUF_W  = $clog2(2*NUM_FIELDS);
  localparam int EN_BIT = FIELD_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else if (ext_we) begin
      map_q[ext_sel] <= ext_wdata;
    end else if (en_we) begin
      map_q[en_buf[0]][FIELD_W*int'(en_buf[BUF_W-1:1]) + EN_BIT] <= en_val;
    end
  end
endmodule

// File: rtl/rdr_field_match.sv
module rdr_field_match #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  parameter int DEV_W      = 2
) (
  input  logic [NUM_FIELDS*FIELD_W-1:0] map_word,
  input  logic [DEV_W-1:0]              dev,
  output logic [NUM_FIELDS-1:0]         hit
);
  localparam int EN_BIT = FIELD_W - 1;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    // channel bit (EN_BIT-1) deliberately left out of the compare
    assign hit[f] = map_word[f*FIELD_W + EN_BIT] &&
                    (map_word[f*FIELD_W +: DEV_W] == dev);
  end
endmodule

// File: rtl/rdr_wait_timer.sv
module rdr_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/resp_drain_seq.sv
module resp_drain_seq
  import rdr_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  parameter int DEV_W      = 2,
  parameter int TMO_W      = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cmd_valid,
  input  logic [1:0]                            cmd_op,
  input  logic [$clog2(2*NUM_FIELDS)-1:0]       cmd_buf,
  input  logic [DEV_W:0]                        cmd_slot,
  input  logic [TMO_W-1:0]                      tmo_limit,
  input  logic [2*NUM_FIELDS-1:0]               buf_inuse,
  input  logic [2*NUM_FIELDS-1:0]               buf_valid,
  input  logic                                  map_we,
  input  logic                                  map_sel,
  input  logic [NUM_FIELDS*FIELD_W-1:0]         map_wdata,
  output logic [2*NUM_FIELDS-1:0]               clr_strobe,
  output logic [NUM_FIELDS*FIELD_W-1:0]         map0_q,
  output logic [NUM_FIELDS*FIELD_W-1:0]         map1_q,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  err
);
  localparam int NUM_BUF  = 2*NUM_FIELDS;
  localparam int MAP_W    = NUM_FIELDS*FIELD_W;
  localparam int BUF_W    = $clog2(NUM_BUF);
  localparam int FLD_W    = BUF_W - 1;
  localparam int EN_BIT   = FIELD_W - 1;
  localparam logic [FLD_W-1:0] LAST_FLD = FLD_W'(NUM_FIELDS-1);

  state_t               state, state_n;
  logic [1:0]           op_q;
  logic [BUF_W-1:0]     cur_buf;
  logic [DEV_W-1:0]     dev_q;
  logic                 saved_en;
  logic                 abort_q;

  logic [1:0][MAP_W-1:0] map_q;
  logic [NUM_FIELDS-1:0] hit_vec;
  logic [FIELD_W-1:0]    field_cur;
  logic [FLD_W-1:0]      fld;
  logic                  inuse_cur, valid_cur;
  logic                  cmd_acc, tmr_restart, tmr_exp, tmo_hit;
  logic                  en_we, en_val, step_fld;
  logic [NUM_BUF-1:0]    strobe_n;

  assign fld       = cur_buf[BUF_W-1:1];
  assign field_cur = map_q[cur_buf[0]][FIELD_W*int'(fld) +: FIELD_W];
  assign inuse_cur = buf_inuse[cur_buf];
  assign valid_cur = buf_valid[cur_buf];
  assign cmd_acc   = (state == S_IDLE) && cmd_valid && (cmd_op != OP_BAD);

  rdr_map_regs #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_map (
    .clk       (clk),
    .rst       (rst),
    .ext_we    (map_we && (state == S_IDLE)),
    .ext_sel   (map_sel),
    .ext_wdata (map_wdata),
    .en_we     (en_we),
    .en_buf    (cur_buf),
    .en_val    (en_val),
    .map_q     (map_q)
  );

  rdr_field_match #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .DEV_W(DEV_W)) u_match (
    .map_word (map_q[cur_buf[0]]),
    .dev      (dev_q),
    .hit      (hit_vec)
  );

  rdr_wait_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .limit   (tmo_limit),
    .expired (tmr_exp)
  );

  // enable bit is dropped on entry to the drain and put back afterwards
  assign en_we  = ((state == S_DIS) && field_cur[EN_BIT]) ||
                  ((state == S_REST) && saved_en);
  assign en_val = (state == S_REST);

  always_comb begin
    state_n     = state;
    tmr_restart = 1'b0;
    tmo_hit     = 1'b0;
    strobe_n    = '0;
    step_fld    = 1'b0;
    case (state)
      S_IDLE: begin
        tmr_restart = 1'b1;
        if (cmd_acc) begin
          case (cmd_op)
            OP_DRAIN: state_n = S_WUSE;
            OP_FLUSH: state_n = S_DIS;
            default:  state_n = S_SCAN;
          endcase
        end
      end
      S_SCAN: begin
        if (hit_vec[fld]) begin
          state_n = S_DIS;
        end else if (fld == LAST_FLD) begin
          state_n = S_FIN;
        end else begin
          step_fld = 1'b1;
        end
      end
      S_DIS: begin
        state_n     = S_WUSE;
        tmr_restart = 1'b1;
      end
      S_WUSE: begin
        if (inuse_cur) begin
          tmo_hit = tmr_exp;
        end else if (valid_cur) begin
          state_n     = S_WVAL;
          strobe_n    = NUM_BUF'(1) << cur_buf;
          tmr_restart = 1'b1;
        end else begin
          state_n = (op_q == OP_DRAIN) ? S_FIN : S_REST;
        end
        if (tmo_hit) state_n = (op_q == OP_DRAIN) ? S_FIN : S_REST;
      end
      S_WVAL: begin
        if (valid_cur) begin
          tmo_hit = tmr_exp;
          if (tmo_hit) state_n = (op_q == OP_DRAIN) ? S_FIN : S_REST;
        end else begin
          state_n = (op_q == OP_DRAIN) ? S_FIN : S_REST;
        end
      end
      S_REST: begin
        if ((op_q == OP_SLOT) && !abort_q && (fld != LAST_FLD)) begin
          state_n  = S_SCAN;
          step_fld = 1'b1;
        end else begin
          state_n = S_FIN;
        end
      end
      S_FIN:   state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_DRAIN;
      cur_buf    <= '0;
      dev_q      <= '0;
      saved_en   <= 1'b0;
      abort_q    <= 1'b0;
      clr_strobe <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      state      <= state_n;
      clr_strobe <= strobe_n;
      busy       <= (state_n != S_IDLE);
      done       <= (state == S_FIN);
      if (cmd_acc) begin
        op_q    <= cmd_op;
        dev_q   <= cmd_slot[DEV_W:1];
        abort_q <= 1'b0;
        err     <= 1'b0;
        if (cmd_op == OP_SLOT) cur_buf <= {FLD_W'(0), cmd_slot[0]};
        else                   cur_buf <= cmd_buf;
      end
      if (state == S_DIS) saved_en <= field_cur[EN_BIT];
      if (state == S_SCAN) saved_en <= 1'b0;
      if (tmo_hit) begin
        err     <= 1'b1;
        abort_q <= 1'b1;
      end
      if (step_fld) cur_buf <= cur_buf + BUF_W'(2);
    end
  end

  assign map0_q = map_q[0];
  assign map1_q = map_q[1];
endmodule

// File: rtl/resp_drain_chk.sv
module resp_drain_chk #(
  parameter int NUM_BUF = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic [NUM_BUF-1:0] clr_strobe,
  input logic [NUM_BUF-1:0] buf_inuse,
  input logic [NUM_BUF-1:0] buf_valid
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_strobe)); // R3

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|clr_strobe) |=> (clr_strobe == '0)); // R3

  AST_STROBE_NOT_INUSE: assert property (@(posedge clk) disable iff (rst)
    (|clr_strobe) |-> ((clr_strobe & $past(buf_inuse)) == '0)); // R2

  AST_STROBE_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    (|clr_strobe) |-> ((clr_strobe & ~$past(buf_valid)) == '0)); // R2

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|clr_strobe) |-> busy); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7

  AST_ERR_IN_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> busy); // R8
endmodule

bind resp_drain_seq resp_drain_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .clr_strobe (clr_strobe),
  .buf_inuse  (buf_inuse),
  .buf_valid  (buf_valid)
);

// File: tb/resp_drain_seq_tb.sv
module resp_drain_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_buf = '0;
  logic [2:0]  cmd_slot = '0;
  logic [15:0] tmo_limit = 16'd30;
  logic [NB-1:0] buf_inuse = '0;
  logic [NB-1:0] buf_valid = '0;
  logic        map_we = 1'b0;
  logic        map_sel = 1'b0;
  logic [31:0] map_wdata = '0;
  logic [NB-1:0] clr_strobe;
  logic [31:0] map0_q, map1_q;
  logic        busy, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_drain_seq u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_buf(cmd_buf), .cmd_slot(cmd_slot), .tmo_limit(tmo_limit),
    .buf_inuse(buf_inuse), .buf_valid(buf_valid), .map_we(map_we),
    .map_sel(map_sel), .map_wdata(map_wdata), .clr_strobe(clr_strobe),
    .map0_q(map0_q), .map1_q(map1_q), .busy(busy), .done(done), .err(err)
  );

  int checks = 0;
  int fails = 0;
  logic [31:0] mdl [2];
  int inuse_left [NB];
  int drop_left [NB];
  int strobe_cnt [NB];
  logic [NB-1:0] stuck_use = '0;
  logic [NB-1:0] stuck_val = '0;
  logic [NB-1:0] v0;
  int last_strobe, order_bad, en_bad, cur_op, cyc;

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
    $finish;
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_target(int op, int bn, int sl, int b);
    logic [31:0] w;
    int f;
    if (op != 2) return (b == bn);
    if ((b & 1) != (sl & 1)) return 1'b0;
    f = b >> 1;
    w = mdl[b & 1];
    return w[4*f+3] && (w[4*f +: 2] == 2'(sl >> 1));
  endfunction

  task automatic step_env();
    logic [31:0] m;
    for (int b = 0; b < NB; b++) begin
      if (clr_strobe[b]) begin
        strobe_cnt[b]++;
        if (b <= last_strobe) order_bad++;
        last_strobe = b;
        m = b[0] ? map1_q : map0_q;
        if (cur_op != 0 && m[4*(b>>1)+3]) en_bad++;
        drop_left[b] = 1 + int'($urandom % 3);
      end
      if (inuse_left[b] > 0) inuse_left[b]--;
      buf_inuse[b] = stuck_use[b] || (inuse_left[b] > 0);
      if (drop_left[b] > 0) begin
        drop_left[b]--;
        if (drop_left[b] == 0 && !stuck_val[b]) buf_valid[b] = 1'b0;
      end
    end
  endtask

  task automatic do_write(bit sel, logic [31:0] data);
    @(negedge clk);
    map_we = 1'b1; map_sel = sel; map_wdata = data;
    @(negedge clk);
    map_we = 1'b0;
    mdl[sel] = data;
  endtask

  task automatic setup_env(logic [NB-1:0] vals, int max_use);
    v0 = vals;
    buf_valid = vals;
    for (int b = 0; b < NB; b++) begin
      inuse_left[b] = (max_use > 0) ? int'($urandom % max_use) : 0;
      drop_left[b] = 0;
      buf_inuse[b] = stuck_use[b] || (inuse_left[b] > 0);
    end
  endtask

  task automatic run_cmd(int op, int bn, int sl, int lim, bit inject);
    cur_op = op; last_strobe = -1; order_bad = 0; en_bad = 0;
    for (int b = 0; b < NB; b++) strobe_cnt[b] = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_buf = 4'(bn); cmd_slot = 3'(sl);
    tmo_limit = 16'(lim);
    cyc = 0;
    while (cyc < 3000) begin
      @(negedge clk);
      cmd_valid = 1'b0; map_we = 1'b0;
      step_env();
      if (done) break;
      if (inject && cyc == 2) begin
        map_we = 1'b1; map_sel = 1'b0; map_wdata = 32'hFFFF_FFFF;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_buf = 4'd14;
      end
      cyc++;
    end
    check(done == 1'b1, "R7 done pulse seen", done, 1);
    check(busy == 1'b0, "R7 busy low with done", busy, 0);
    @(negedge clk);
    step_env();
    check(done == 1'b0, "R7 done one cycle", done, 0);
  endtask

  task automatic check_strobes(int op, int bn, int sl, string tag);
    int bad = 0;
    int first_bad = -1;
    for (int b = 0; b < NB; b++) begin
      if (strobe_cnt[b] != ((is_target(op, bn, sl, b) && v0[b]) ? 1 : 0)) begin
        bad++;
        if (first_bad < 0) first_bad = b;
      end
    end
    check(bad == 0, tag, first_bad, -1);
  endtask

  initial begin
    mdl[0] = '0; mdl[1] = '0;
    for (int b = 0; b < NB; b++) begin
      inuse_left[b] = 0; drop_left[b] = 0; strobe_cnt[b] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({busy, done, err} == 3'b000, "R1 flags after reset", {busy, done, err}, 0);
    check(clr_strobe == '0, "R1 strobe after reset", clr_strobe, 0);
    check({map0_q, map1_q} == 64'd0, "R1 maps after reset", {map0_q, map1_q}, 0);

    // R2 valid already low: no strobe
    do_write(0, 32'h0000_0000);
    setup_env(16'h0000, 0);
    inuse_left[6] = 4; buf_inuse[6] = 1'b1;
    run_cmd(0, 6, 0, 30, 0);
    check(strobe_cnt[6] == 0, "R2 no strobe when valid low", strobe_cnt[6], 0);

    // R2 drain with data present
    setup_env(16'h0040, 0);
    inuse_left[6] = 5; buf_inuse[6] = 1'b1;
    run_cmd(0, 6, 0, 30, 0);
    check(strobe_cnt[6] == 1, "R2 single strobe on valid buffer", strobe_cnt[6], 1);
    check(buf_valid[6] == 1'b0, "R2 valid drained", buf_valid[6], 0);

    // R4/R5 flush of an enabled field
    do_write(1, 32'h0000_A000);
    setup_env(16'h0080, 4);
    run_cmd(1, 7, 0, 30, 0);
    check(strobe_cnt[7] == 1, "R4 flush strobe", strobe_cnt[7], 1);
    check(en_bad == 0, "R4 enable low during drain", en_bad, 0);
    check(map1_q == 32'h0000_A000, "R5 field restored", map1_q, 32'h0000_A000);

    // R6 slot flush: even map, device 1, channel ignored
    do_write(0, 32'h00D0_A9D9);
    do_write(1, 32'h00D0_A9D9);
    setup_env(16'hFFFF, 3);
    run_cmd(2, 0, 3'b010, 30, 0);
    check_strobes(2, 0, 3'b010, "R6 slot match set");
    check(strobe_cnt[0] == 1 && strobe_cnt[2] == 1 && strobe_cnt[10] == 1,
          "R6 buffers 0 2 10 flushed", strobe_cnt[10], 1);
    check(order_bad == 0, "R6 ascending order", order_bad, 0);
    check(map0_q == 32'h00D0_A9D9, "R5 slot map restored", map0_q, 32'h00D0_A9D9);

    // R8 in-use stuck on first match: error, restore, later fields skipped
    do_write(0, 32'h0009_00D0);
    stuck_use = '0; stuck_use[2] = 1'b1;
    setup_env(16'hFFFF, 0);
    run_cmd(2, 0, 3'b010, 5, 0);
    check(err == 1'b1, "R8 err on in-use timeout", err, 1);
    check(strobe_cnt[8] == 0 && strobe_cnt[2] == 0, "R8 no strobes after abort",
          strobe_cnt[8], 0);
    check(map0_q == 32'h0009_00D0, "R8 enable restored", map0_q, 32'h0009_00D0);
    stuck_use = '0;

    // R8 valid stuck after the strobe
    stuck_val = '0; stuck_val[5] = 1'b1;
    setup_env(16'h0020, 0);
    run_cmd(0, 5, 0, 6, 0);
    check(strobe_cnt[5] == 1, "R8 strobe before valid timeout", strobe_cnt[5], 1);
    check(err == 1'b1, "R8 err on valid timeout", err, 1);
    stuck_val = '0;

    // R9 writes and commands ignored while busy
    do_write(0, 32'h1234_5678);
    stuck_use[3] = 1'b1;
    setup_env(16'h4008, 0);
    run_cmd(0, 3, 0, 40, 1);
    check(map0_q == 32'h1234_5678, "R9 map write blocked", map0_q, 32'h1234_5678);
    check(strobe_cnt[14] == 0, "R9 second command ignored", strobe_cnt[14], 0);
    stuck_use = '0;

    // R9 reserved op never accepted
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b0, "R9 op 3 ignored", busy, 0);

    // R8 err cleared by next command
    setup_env(16'h0000, 0);
    run_cmd(0, 1, 0, 30, 0);
    check(err == 1'b0, "R8 err cleared on accept", err, 1'b0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op, bn, sl;
      do_write(0, $urandom);
      do_write(1, $urandom);
      setup_env(NB'($urandom), 6);
      op = int'($urandom % 3);
      bn = int'($urandom % NB);
      sl = int'($urandom % 8);
      run_cmd(op, bn, sl, 30, 0);
      check_strobes(op, bn, sl, (op == 0) ? "R2 random drain" :
                                (op == 1) ? "R4 random flush" : "R6 random slot");
      check(order_bad == 0, "R6 random order", order_bad, 0);
      check(en_bad == 0, "R4 random enable low", en_bad, 0);
      check(map0_q == mdl[0] && map1_q == mdl[1], "R5 random maps kept",
            {map0_q, map1_q}, {mdl[0], mdl[1]});
      check(err == 1'b0, "R8 no spurious err", err, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule